// File: doc/BRIEF.md
# Processor Reset Sequencer with Mode Latch

This block generates the internal reset of a processor-style bus master from an asynchronous, active-low board reset. The board reset is brought into the bus clock domain through a chain of flip-flops. Its release then starts a counter that keeps the internal reset asserted for a fixed number of further clocks. If the board reset returns during that window, the counter is reloaded. The next release restarts the window in full.

When the synchronized release is first seen, the block captures a set of mode-select pins: a cache-disable bit, a memory-management-disable bit and a 3-bit interrupt-level field. It holds them as registered outputs until the next reset. After the internal reset ends, the bus output-enable stays off until a bus grant is sampled. The block then raises the output-enable and gives a single-clock pulse that starts the first bus cycle.

Top module: `cpu_reset_seq`

## Requirements
- R1: The board reset release reaches the stretch logic through a two-flop synchronizer, so the release takes effect on the second rising clock edge after it.
- R2: With the default stretch of 128, `in_reset_o` falls on exactly the 130th rising edge after `ext_rst_n_i` rises. This is 2 synchronizer edges plus 128 stretch edges.
- R3: A board reset asserted during the stretch keeps `in_reset_o` high and reloads the counter. The full 130-edge interval is then counted again from the next release.
- R4: `in_reset_o` reads 1 from the first rising edge at which the board reset is asserted, and at power-up.
- R5: `bus_oe_o` and `first_cycle_o` read 0 whenever `in_reset_o` is 1.
- R6: The mode outputs take the pin values present at the 3rd rising edge after the board reset rises. A pin change made after the 2nd edge is captured. Fields: `cache_off_o`, `mmu_off_o` and `irq_lvl_o[2:0]`, each mirroring the pin of the same name.
- R7: After capture, the mode outputs ignore pin changes until the next reset. While the reset is active they read 0.
- R8: `bus_oe_o` rises at the first rising edge at which internal reset is already low and `bus_grant_i` is high. It then stays high until the next reset, even if the grant drops.
- R9: `first_cycle_o` is high for exactly one clock per reset release, on the same cycle that `bus_oe_o` first reads 1.
- R10: A grant held high throughout reset has no early effect. `bus_oe_o` rises one edge after `in_reset_o` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| ext_rst_n_i | input | 1 | Asynchronous board reset, active low |
| cache_off_pin_i | input | 1 | Cache-disable mode pin |
| mmu_off_pin_i | input | 1 | Memory-management-disable mode pin |
| irq_lvl_pin_i | input | 3 | Interrupt-level mode pins |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| in_reset_o | output | 1 | High while the block is in reset |
| bus_oe_o | output | 1 | Output-enable for the bus drivers |
| first_cycle_o | output | 1 | One-clock start pulse for the first bus cycle |
| cache_off_o | output | 1 | Captured cache-disable bit |
| mmu_off_o | output | 1 | Captured memory-management-disable bit |
| irq_lvl_o | output | 3 | Captured interrupt-level field |

## Verification
The stretch is exercised in two ways. A clean release tells the synchronizer delay and the exact count apart from an off-by-one. A release interrupted by a one-cycle board reset shows whether the counter reloads or only pauses. Mode pins are changed just before and just after the capture edge, and again later, to separate the capture instant from continuous tracking. The grant is applied in two ways: late, after reset ends, and early, held through the whole reset. Together these show that the enable waits for both conditions and that the start pulse fires once.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int IRQ_W = 3;

  typedef struct packed {
    logic             cache_off;
    logic             mmu_off;
    logic [IRQ_W-1:0] irq_lvl;
  } mode_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rel_o
);
  logic [STAGES-1:0] chain_q = '0;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rel_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
  parameter int STRETCH = 128
) (
  input  logic clk_i,
  input  logic rel_i,
  output logic core_rst_o
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam int SW = $clog2(STRETCH + 2);

  logic [CW-1:0] cnt_q      = CW'(STRETCH);
  logic          core_rst_q = 1'b1;

  always_ff @(posedge clk_i) begin
    if (!rel_i) begin
      cnt_q      <= CW'(STRETCH);
      core_rst_q <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      core_rst_q <= (cnt_q > CW'(1));
    end
  end

  assign core_rst_o = core_rst_q;

  // Independent window counter for checking the release distance
  logic [SW-1:0] since_rel_q = '0;
  always_ff @(posedge clk_i) begin
    if (!rel_i)                             since_rel_q <= '0;
    else if (since_rel_q != SW'(STRETCH+1)) since_rel_q <= since_rel_q + SW'(1);
  end

  // R2
  stretch_len_chk: assert property (@(posedge clk_i) disable iff (!rel_i)
    $fell(core_rst_q) |-> (since_rel_q == SW'(STRETCH)));

  // R3
  held_in_reset_chk: assert property (@(posedge clk_i)
    !rel_i |=> core_rst_q);
endmodule

// File: rtl/rstseq_mode.sv
module rstseq_mode
  import rstseq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rel_i,
  input  mode_t pins_i,
  output mode_t mode_o
);
  logic  seen_q = 1'b0;
  mode_t mode_q = '0;

  always_ff @(posedge clk_i) begin
    if (!rel_i) begin
      seen_q <= 1'b0;
      mode_q <= '0;
    end else if (!seen_q) begin
      seen_q <= 1'b1;
      mode_q <= pins_i;
    end
  end

  assign mode_o = mode_q;

  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rel_i)
    seen_q |=> $stable(mode_q));
endmodule

// File: rtl/rstseq_busgate.sv
module rstseq_busgate (
  input  logic clk_i,
  input  logic rel_i,
  input  logic core_rst_i,
  input  logic grant_i,
  output logic bus_oe_o,
  output logic start_o
);
  logic own_q   = 1'b0;
  logic start_q = 1'b0;

  always_ff @(posedge clk_i) begin
    if (!rel_i) begin
      own_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= !core_rst_i && grant_i && !own_q;
      if (!core_rst_i && grant_i) own_q <= 1'b1;
    end
  end

  assign bus_oe_o = own_q;
  assign start_o  = start_q;

  // R5
  oe_off_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rel_i)
    own_q |-> !core_rst_i);

  // R9
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rel_i)
    start_q |=> !start_q);

  // R9
  start_with_oe_chk: assert property (@(posedge clk_i) disable iff (!rel_i)
    start_q |-> own_q);
endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
  import rstseq_pkg::*;
#(
  parameter int STRETCH_CYCLES = 128,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk_i,
  input  logic             ext_rst_n_i,
  input  logic             cache_off_pin_i,
  input  logic             mmu_off_pin_i,
  input  logic [IRQ_W-1:0] irq_lvl_pin_i,
  input  logic             bus_grant_i,
  output logic             in_reset_o,
  output logic             bus_oe_o,
  output logic             first_cycle_o,
  output logic             cache_off_o,
  output logic             mmu_off_o,
  output logic [IRQ_W-1:0] irq_lvl_o
);
  logic  rel;
  logic  core_rst;
  mode_t pins;
  mode_t mode;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .arst_n_i (ext_rst_n_i),
    .rel_o    (rel)
  );

  rstseq_stretch #(.STRETCH(STRETCH_CYCLES)) u_stretch (
    .clk_i      (clk_i),
    .rel_i      (rel),
    .core_rst_o (core_rst)
  );

  assign pins.cache_off = cache_off_pin_i;
  assign pins.mmu_off   = mmu_off_pin_i;
  assign pins.irq_lvl   = irq_lvl_pin_i;

  rstseq_mode u_mode (
    .clk_i  (clk_i),
    .rel_i  (rel),
    .pins_i (pins),
    .mode_o (mode)
  );

  rstseq_busgate u_gate (
    .clk_i      (clk_i),
    .rel_i      (rel),
    .core_rst_i (core_rst),
    .grant_i    (bus_grant_i),
    .bus_oe_o   (bus_oe_o),
    .start_o    (first_cycle_o)
  );

  assign in_reset_o  = core_rst;
  assign cache_off_o = mode.cache_off;
  assign mmu_off_o   = mode.mmu_off;
  assign irq_lvl_o   = mode.irq_lvl;
endmodule

// File: tb/cpu_reset_seq_test.sv
module cpu_reset_seq_test;
  localparam int STRETCH = 128;
  localparam int LAT     = STRETCH + 2;

  logic       clk = 1'b0;
  logic       ext_rst_n = 1'b0;
  logic       cpin = 1'b0, mpin = 1'b0;
  logic [2:0] ipin = 3'd0;
  logic       grant = 1'b0;
  logic       in_reset, bus_oe, first_cycle, cache_off, mmu_off;
  logic [2:0] irq_lvl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cpu_reset_seq #(.STRETCH_CYCLES(STRETCH)) uut (
    .clk_i(clk), .ext_rst_n_i(ext_rst_n),
    .cache_off_pin_i(cpin), .mmu_off_pin_i(mpin), .irq_lvl_pin_i(ipin),
    .bus_grant_i(grant), .in_reset_o(in_reset), .bus_oe_o(bus_oe),
    .first_cycle_o(first_cycle), .cache_off_o(cache_off),
    .mmu_off_o(mmu_off), .irq_lvl_o(irq_lvl)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mode_word();
    return {cache_off, mmu_off, irq_lvl};
  endfunction

  // Release the board reset and count edges until internal reset drops.
  // Pins go to value B after edge 2 and to value C after edge 3.
  task automatic release_and_count(output int edges, output int oe_seen);
    edges = 0; oe_seen = 0;
    ext_rst_n = 1'b1;
    do begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (bus_oe || first_cycle) oe_seen = 1;
      if (edges == 2) begin cpin = 1'b0; mpin = 1'b1; ipin = 3'd3; end
      if (edges == 3) begin cpin = 1'b1; mpin = 1'b1; ipin = 3'd7; end
    end while (in_reset && edges < 1000);
  endtask

  task automatic t_powerup();
    repeat (4) @(negedge clk);
    chk("R4 in_reset at power-up", in_reset, 1);
    chk("R5 bus_oe in reset", bus_oe, 0);
    chk("R5 first_cycle in reset", first_cycle, 0);
    chk("R7 mode zero in reset", mode_word(), 0);
  endtask

  task automatic t_clean_release();
    int edges, oe_seen;
    cpin = 1'b1; mpin = 1'b0; ipin = 3'd5;
    release_and_count(edges, oe_seen);
    chk("R1 R2 release-to-run edges", edges, LAT);
    chk("R5 no enable during stretch", oe_seen, 0);
    chk("R6 captured pins after edge 2", mode_word(), {1'b0, 1'b1, 3'd3});
    repeat (10) @(negedge clk);
    chk("R8 no enable without grant", bus_oe, 0);
    chk("R9 no start without grant", first_cycle, 0);
    grant = 1'b1;
    @(negedge clk);
    chk("R8 enable on grant", bus_oe, 1);
    chk("R9 start pulse", first_cycle, 1);
    @(negedge clk);
    chk("R9 start pulse ends", first_cycle, 0);
    grant = 1'b0; cpin = 1'b0; mpin = 1'b0; ipin = 3'd1;
    repeat (5) @(negedge clk);
    chk("R8 enable held after grant drop", bus_oe, 1);
    chk("R9 single start", first_cycle, 0);
    chk("R7 mode ignores pin change", mode_word(), {1'b0, 1'b1, 3'd3});
  endtask

  task automatic t_restart();
    int edges, oe_seen, broke;
    ext_rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R4 in_reset after assertion", in_reset, 1);
    chk("R5 bus_oe off in reset", bus_oe, 0);
    chk("R7 mode cleared in reset", mode_word(), 0);
    grant = 1'b1;
    cpin = 1'b0; mpin = 1'b0; ipin = 3'd2;
    ext_rst_n = 1'b1;
    broke = 0;
    repeat (50) begin
      @(negedge clk);
      if (!in_reset) broke = 1;
    end
    ext_rst_n = 1'b0;
    @(negedge clk);
    if (!in_reset) broke = 1;
    release_and_count(edges, oe_seen);
    chk("R3 reset held across interruption", broke, 0);
    chk("R3 full interval after reload", edges, LAT);
    chk("R10 early grant ignored", oe_seen, 0);
    chk("R6 capture on second release", mode_word(), {1'b0, 1'b1, 3'd3});
    @(negedge clk);
    chk("R10 enable one edge after reset", bus_oe, 1);
    chk("R9 start with enable", first_cycle, 1);
    @(negedge clk);
    chk("R9 start one clock", first_cycle, 0);
  endtask

  initial begin
    t_powerup();
    t_clean_release();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule